// File: doc/BRIEF.md
# Serial-In Parallel-Out Latched Shifter

The block turns a serial bit stream into a parallel word. A serial data bit enters an internal chain of shift stages on each rising edge of a shift clock. On a rising edge of a separate latch clock, the whole chain is copied into a parallel output register. The chain's last stage also appears on a serial cascade output, so several instances can be chained outside the block. An active-low clear empties the chain and leaves the parallel register alone. An active-low output enable either drives the parallel word or releases the bus. The released state is modelled as a drive flag, with the data bus forced to zero.

The shift clock, the latch clock, the clear, the serial data and the enable are ordinary signals sampled in the system clock domain. A small controller samples the shift clock, the latch clock, the clear and the serial data once, keeps the previous samples of both clocks to find rising edges, and decodes one operation per cycle into its state register. The states are ST_IDLE, ST_SHIFT, ST_LATCH, ST_SHIFT_LATCH, ST_CLEAR and ST_CLEAR_LATCH. Every cycle the controller moves to the state that the current samples select. When the sampled clear is low, it goes to ST_CLEAR_LATCH if a latch edge is present and to ST_CLEAR otherwise. When the clear is high, it goes to ST_SHIFT_LATCH, ST_SHIFT, ST_LATCH or ST_IDLE, depending on which of the two edges are present. The datapath carries out the operation named by the state one cycle later. An input change therefore takes effect three system clocks after it is applied. The enable is sampled once, so it takes effect one system clock after it is applied.

Top module: `sipo_latched_shifter`

## Requirements
- R1: On a rising shift-clock edge with clear high, the serial input enters stage 0 and every stage n takes the former value of stage n-1.
- R2: On a rising latch-clock edge, all stages are copied to the parallel register, and the stages keep their values.
- R3: While clear is low, the stages are zero and the parallel register keeps its value.
- R4: With output enable high, q_drive_o is 0 and q_o is 0. With it low, q_drive_o is 1 and q_o carries the parallel register, which is unaffected by the enable.
- R5: ser_o always equals the last stage, and a latch-only operation leaves it unchanged.
- R6: When the shift and latch edges arrive in the same sample, the shift happens and the parallel register takes the stage values from before that shift.
- R7: q_o[0] is the least significant bit. Eight bits sent most significant bit first appear as that byte on q_o[7:0].
- R8: After system reset the stages and the parallel register are zero and ser_o is 0.
- R9: Only rising edges act. A clock held high shifts once, and the serial input changing while the clock is high has no effect.
- R10: While clear is low, a shift edge is ignored, and a latch edge copies the cleared (all-zero) stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| sys_rst_n_i | input | 1 | Synchronous system reset, active low |
| shift_clk_i | input | 1 | Shift clock, acts on its rising edge |
| latch_clk_i | input | 1 | Latch clock, acts on its rising edge |
| ser_i | input | 1 | Serial data in |
| clr_n_i | input | 1 | Clear of the shift stages, active low |
| oe_n_i | input | 1 | Output enable, active low |
| q_o | output | WIDTH | Parallel output, zero when released |
| q_drive_o | output | 1 | 1 when q_o is being driven |
| ser_o | output | 1 | Serial cascade output, last stage |

## Verification
The bench builds the block with WIDTH = 8, so a full byte reaches q_o after eight shift edges. The bit order can then be checked against patterns such as 0xD5, 0x3C and 0xA5. At this width ser_o shows stage 7 after every single shift, so each step of the chain is visible at the port. The same width lets the bench check the corner cases against whole bytes: simultaneous shift and latch, a latch edge during clear, and a clock level held high.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

    // Operation carried out by the datapath in the cycle after decode.
    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_SHIFT       = 3'd1,
        ST_LATCH       = 3'd2,
        ST_SHIFT_LATCH = 3'd3,
        ST_CLEAR       = 3'd4,
        ST_CLEAR_LATCH = 3'd5
    } sipo_state_e;

endpackage

// File: rtl/sipo_edge.sv
// Samples a level and flags its rising edge against the previous sample.
module sipo_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    logic lvl_s;
    logic lvl_p;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_s <= 1'b0;
            lvl_p <= 1'b0;
        end else begin
            lvl_s <= lvl_i;
            lvl_p <= lvl_s;
        end
    end

    assign rise_o = lvl_s & ~lvl_p;
endmodule

// File: rtl/sipo_ctrl.sv
// Samples the control inputs, decodes one operation per cycle.
module sipo_ctrl
    import sipo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic shift_clk_i,
    input  logic latch_clk_i,
    input  logic ser_i,
    input  logic clr_n_i,
    output logic do_shift_o,
    output logic do_latch_o,
    output logic do_clear_o,
    output logic ser_bit_o
);
    logic        shift_rise;
    logic        latch_rise;
    logic        ser_s;
    logic        clr_n_s;
    logic        ser_op_q;
    sipo_state_e state_q;
    sipo_state_e state_d;

    sipo_edge u_shift_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (shift_clk_i),
        .rise_o(shift_rise)
    );

    sipo_edge u_latch_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (latch_clk_i),
        .rise_o(latch_rise)
    );

    // Data and clear are sampled in step with the clock samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_s   <= 1'b0;
            clr_n_s <= 1'b1;
        end else begin
            ser_s   <= ser_i;
            clr_n_s <= clr_n_i;
        end
    end

    // Next-state decode: clear has priority over shifting.
    always_comb begin
        state_d = ST_IDLE;
        if (!clr_n_s) begin
            state_d = latch_rise ? ST_CLEAR_LATCH : ST_CLEAR;
        end else begin
            unique case ({shift_rise, latch_rise})
                2'b11:   state_d = ST_SHIFT_LATCH;
                2'b10:   state_d = ST_SHIFT;
                2'b01:   state_d = ST_LATCH;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register, with the serial bit that belongs to the operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            ser_op_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            ser_op_q <= ser_s;
        end
    end

    // Output decode of the state.
    always_comb begin
        do_shift_o = 1'b0;
        do_latch_o = 1'b0;
        do_clear_o = 1'b0;
        unique case (state_q)
            ST_IDLE:        ;
            ST_SHIFT:       do_shift_o = 1'b1;
            ST_LATCH:       do_latch_o = 1'b1;
            ST_SHIFT_LATCH: begin
                do_shift_o = 1'b1;
                do_latch_o = 1'b1;
            end
            ST_CLEAR:       do_clear_o = 1'b1;
            ST_CLEAR_LATCH: begin
                do_clear_o = 1'b1;
                do_latch_o = 1'b1;
            end
            default:        ;
        endcase
    end

    assign ser_bit_o = ser_op_q;
endmodule

// File: rtl/sipo_shift.sv
// Chain of shift stages; stage 0 takes the serial bit.
module sipo_shift #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_shift,
    input  logic             do_clear,
    input  logic             ser_bit,
    output logic [WIDTH-1:0] stages_o
);
    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] feed;

    assign feed[0] = ser_bit;

    for (genvar g = 1; g < WIDTH; g++) begin : g_feed
        assign feed[g] = stage_q[g-1];
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n || do_clear) begin
                stage_q[g] <= 1'b0;
            end else if (do_shift) begin
                stage_q[g] <= feed[g];
            end
        end
    end

    assign stages_o = stage_q;
endmodule

// File: rtl/sipo_latch.sv
// Parallel output register with released-bus model.
module sipo_latch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_latch,
    input  logic [WIDTH-1:0] stages_i,
    input  logic             oe_n_i,
    output logic [WIDTH-1:0] latch_o,
    output logic [WIDTH-1:0] q_o,
    output logic             drive_o
);
    logic [WIDTH-1:0] hold_q;
    logic             drive_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            drive_q <= 1'b0;
        end else begin
            drive_q <= ~oe_n_i;
            if (do_latch) begin
                hold_q <= stages_i;
            end
        end
    end

    assign latch_o = hold_q;
    assign drive_o = drive_q;
    assign q_o     = drive_q ? hold_q : '0;
endmodule

// File: rtl/sipo_latched_shifter.sv
module sipo_latched_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             sys_rst_n_i,
    input  logic             shift_clk_i,
    input  logic             latch_clk_i,
    input  logic             ser_i,
    input  logic             clr_n_i,
    input  logic             oe_n_i,
    output logic [WIDTH-1:0] q_o,
    output logic             q_drive_o,
    output logic             ser_o
);
    localparam int LAST = WIDTH - 1;

    logic             do_shift;
    logic             do_latch;
    logic             do_clear;
    logic             ser_bit;
    logic [WIDTH-1:0] stages;
    logic [WIDTH-1:0] latch_val;

    sipo_ctrl u_ctrl (
        .clk        (clk_i),
        .rst_n      (sys_rst_n_i),
        .shift_clk_i(shift_clk_i),
        .latch_clk_i(latch_clk_i),
        .ser_i      (ser_i),
        .clr_n_i    (clr_n_i),
        .do_shift_o (do_shift),
        .do_latch_o (do_latch),
        .do_clear_o (do_clear),
        .ser_bit_o  (ser_bit)
    );

    sipo_shift #(.WIDTH(WIDTH)) u_shift (
        .clk     (clk_i),
        .rst_n   (sys_rst_n_i),
        .do_shift(do_shift),
        .do_clear(do_clear),
        .ser_bit (ser_bit),
        .stages_o(stages)
    );

    sipo_latch #(.WIDTH(WIDTH)) u_latch (
        .clk     (clk_i),
        .rst_n   (sys_rst_n_i),
        .do_latch(do_latch),
        .stages_i(stages),
        .oe_n_i  (oe_n_i),
        .latch_o (latch_val),
        .q_o     (q_o),
        .drive_o (q_drive_o)
    );

    assign ser_o = stages[LAST];
endmodule

// File: rtl/sipo_latched_shifter_chk.sv
module sipo_latched_shifter_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             do_shift,
    input logic             do_latch,
    input logic             do_clear,
    input logic             ser_bit,
    input logic [WIDTH-1:0] stages,
    input logic [WIDTH-1:0] latch_val,
    input logic [WIDTH-1:0] q_o,
    input logic             q_drive_o,
    input logic             ser_o
);
    // R1
    shift_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_shift && !do_clear |=>
            stages == {$past(stages[WIDTH-2:0]), $past(ser_bit)});

    // R2
    latch_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_latch |=> latch_val == $past(stages));

    // R2
    latch_keeps_stages_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_latch && !do_shift && !do_clear |=> $stable(stages));

    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_clear |=> stages == '0);

    // R3
    clear_keeps_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_clear && !do_latch |=> $stable(latch_val));

    // R4
    driven_bus_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_drive_o && $past(q_drive_o) && $stable(latch_val) |-> $stable(q_o));

    // R5
    ser_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !do_shift && !do_clear |=> $stable(ser_o));

    // R10
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !do_shift || !do_clear);
endmodule

bind sipo_latched_shifter sipo_latched_shifter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk_i),
    .rst_n    (sys_rst_n_i),
    .do_shift (do_shift),
    .do_latch (do_latch),
    .do_clear (do_clear),
    .ser_bit  (ser_bit),
    .stages   (stages),
    .latch_val(latch_val),
    .q_o      (q_o),
    .q_drive_o(q_drive_o),
    .ser_o    (ser_o)
);

// File: tb/sipo_latched_shifter_bench.sv
module sipo_latched_shifter_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         shclk;
    logic         laclk;
    logic         ser;
    logic         clr_n;
    logic         oe_n;
    logic [W-1:0] q;
    logic         drv;
    logic         sdo;

    always #4 clk = ~clk;

    sipo_latched_shifter #(.WIDTH(W)) u_sipo_latched_shifter (
        .clk_i      (clk),
        .sys_rst_n_i(rst_n),
        .shift_clk_i(shclk),
        .latch_clk_i(laclk),
        .ser_i      (ser),
        .clr_n_i    (clr_n),
        .oe_n_i     (oe_n),
        .q_o        (q),
        .q_drive_o  (drv),
        .ser_o      (sdo)
    );

    typedef struct {
        logic [W-1:0] q;
        logic         drv;
        logic         sdo;
        string        tag;
    } exp_t;

    exp_t         exp_q[$];
    event         chk_ev;
    int           errors = 0;
    int           checks = 0;
    bit           done   = 1'b0;
    logic [W-1:0] m_sr;
    logic [W-1:0] m_lt;
    logic         m_oe_n;

    // Monitor: pops expected items and compares with the ports.
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (q !== e.q || drv !== e.drv || sdo !== e.sdo) begin
                    errors++;
                    $display("FAIL %s: q=%h drv=%b sdo=%b expected q=%h drv=%b sdo=%b",
                             e.tag, q, drv, sdo, e.q, e.drv, e.sdo);
                end
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input string tag);
        exp_t e;
        e.q   = m_oe_n ? '0 : m_lt;
        e.drv = ~m_oe_n;
        e.sdo = m_sr[W-1];
        e.tag = tag;
        exp_q.push_back(e);
        ->chk_ev;
    endtask

    task automatic pulse(input bit sh, input bit la, input bit d, input bit mr,
                         input string tag);
        logic [W-1:0] old;
        ser   = d;
        clr_n = mr;
        wait_n(4);
        shclk = sh;
        laclk = la;
        wait_n(4);
        if (!mr) begin
            m_sr = '0;
            if (la) m_lt = '0;
        end else begin
            old = m_sr;
            if (sh) m_sr = {m_sr[W-2:0], d};
            if (la) m_lt = old;
        end
        shclk = 1'b0;
        laclk = 1'b0;
        wait_n(4);
        clr_n = 1'b1;
        wait_n(4);
        push(tag);
    endtask

    task automatic send_byte(input logic [7:0] b, input string tag);
        for (int i = 7; i >= 0; i--) begin
            pulse(1'b1, 1'b0, b[i], 1'b1, $sformatf("%s bit %0d", tag, i));
        end
    endtask

    task automatic set_oe(input bit v, input string tag);
        oe_n   = v;
        m_oe_n = v;
        wait_n(4);
        push(tag);
    endtask

    initial begin
        rst_n  = 1'b0;
        shclk  = 1'b0;
        laclk  = 1'b0;
        ser    = 1'b0;
        clr_n  = 1'b1;
        oe_n   = 1'b0;
        m_sr   = '0;
        m_lt   = '0;
        m_oe_n = 1'b0;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(3);
        push("R8 reset state");

        send_byte(8'hD5, "R1 R5 shift D5");
        pulse(1'b0, 1'b1, 1'b0, 1'b1, "R2 R7 latch D5");
        pulse(1'b0, 1'b1, 1'b1, 1'b1, "R5 latch-only keeps serial out");

        send_byte(8'h3C, "R1 shift 3C while latch holds");
        set_oe(1'b1, "R4 bus released");
        pulse(1'b0, 1'b1, 1'b0, 1'b1, "R4 latch while released");
        set_oe(1'b0, "R4 bus driven with 3C");

        pulse(1'b0, 1'b0, 1'b0, 1'b0, "R3 clear keeps latch");

        send_byte(8'hA5, "R1 shift A5");
        pulse(1'b1, 1'b1, 1'b1, 1'b1, "R6 shift and latch together");

        pulse(1'b1, 1'b0, 1'b1, 1'b0, "R10 shift ignored during clear");
        pulse(1'b0, 1'b1, 1'b0, 1'b0, "R10 latch during clear takes zeros");

        send_byte(8'h81, "R1 shift 81");
        ser   = 1'b1;
        shclk = 1'b1;
        wait_n(4);
        m_sr = {m_sr[W-2:0], 1'b1};
        ser  = 1'b0;
        wait_n(4);
        shclk = 1'b0;
        wait_n(4);
        push("R9 held level shifts once");
        pulse(1'b0, 1'b1, 1'b0, 1'b1, "R9 R7 latch after held level");

        wait_n(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule